// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counting timer for a small processor subsystem. Software reaches it through three word-wide registers on a single-cycle read/write strobe bus: a control word, a reload value and the live counter value. Once enabled, the counter steps down once per tick. When it reaches zero, the next tick loads the reload value. Each step from one to zero is a wrap. A wrap sets a sticky flag and, if interrupts are allowed, fires a one-cycle interrupt request.

A tick is either every core clock cycle or every cycle on which an external reference strobe, after a synchroniser, is high. To get a period of N ticks, software writes N-1 into the reload register. Any write to the value register zeroes the counter, so the next tick starts a fresh period.

Top module: `systick_timer`

## Requirements
- R1: After reset, the control bits, the wrap flag, the reload value and the counter all read zero, and `irq` is low.
- R2: The registers are decoded at full addresses from BASE = 0xE000E010. Control is at BASE+0, reload at BASE+4 and counter value at BASE+8. Any other address reads zero and ignores writes. Read data appears on `bus_rdata` in the cycle after `bus_rd` and is zero in every other cycle.
- R3: The reload and value fields are 24 bits wide. Bits 31:24 of either register read zero, and writes to those bits are discarded.
- R4: While enabled, each tick decrements a non-zero counter and reloads a zero counter from the reload register. With reload value R, wraps are R+1 ticks apart.
- R5: A write of any data to the value register clears the counter to zero and clears the wrap flag. This write takes priority over a tick in the same cycle, and the next tick loads the reload value.
- R6: The control word has three bits: bit 0 enables counting, bit 1 enables the interrupt and bit 2 selects the clock (1 = core clock, 0 = external strobe). Bit 16 is the wrap flag, which is read-only. The flag is set by a wrap and cleared by a read of the control register, and that read still returns the flag as set. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R7: When bit 1 was set in the cycle of a wrap, `irq` is high for exactly the next cycle. With bit 1 clear, `irq` stays low even though the flag is still set.
- R8: With a reload value of zero and counting enabled, the counter stays at zero and no wrap occurs.
- R9: With the external source selected, the counter moves only on cycles where `ref_tick`, delayed by a two-stage synchroniser, is high.
- R10: With bit 0 clear, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| ref_tick | input | 1 | External reference strobe, asynchronous |
| irq | output | 1 | One-cycle interrupt request per wrap |

## Verification
The bench builds the block with its defaults: a 24-bit counter, a two-stage synchroniser and base 0xE000E010. Reload values of 0, 3 and 4 keep full periods within a few cycles, so the reload-from-zero step, the period length, the zero-reload stall and the flag clear-on-read can all be seen many times. Because the field is 24 bits, writing 0xFF into the top byte is enough to show that the mask discards those bits. With the short synchroniser, an alternating strobe pattern shows the two-cycle delay before the counter steps.

// File: rtl/systick_pkg.sv
package systick_pkg;

  // Register selected by a bus access
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_LOAD = 2'd2,
    SEL_CUR  = 2'd3
  } reg_sel_e;

  // Control bit positions visible to software
  localparam int CTL_EN   = 0;
  localparam int CTL_IE   = 1;
  localparam int CTL_SRC  = 2;
  localparam int CTL_FLAG = 16;

  typedef struct packed {
    logic src;  // 1: core clock, 0: external strobe
    logic ie;   // interrupt on wrap
    logic en;   // counting enabled
  } ctrl_t;

endpackage

// File: rtl/systick_sync.sv
module systick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];

endmodule

// File: rtl/systick_count.sv
module systick_count #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count,
  output logic          wrap
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= (cnt == '0) ? reload : cnt - CW'(1);
  end

  assign count = cnt;
  assign wrap  = tick && !clr && (cnt == CW'(1));

  // R4: a tick on a non-zero count steps down by one
  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

  // R4: a tick on zero loads the reload value
  a_r4_reload_at_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && cnt == '0) |=> (cnt == $past(reload)));

  // R5: a value-register write zeroes the counter
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  // R8: zero reload keeps a zero counter at zero
  a_r8_zero_reload_holds: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && reload == '0) |=> (cnt == '0));

  // R10: no tick, no clear, no movement
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt));

endmodule

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter int          AW   = 32,
  parameter int          DW   = 32,
  parameter int          CW   = 24,
  parameter logic [AW-1:0] BASE = 32'hE000E010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] count,
  input  logic          wrap,
  output ctrl_t         ctrl,
  output logic [CW-1:0] reload,
  output logic          clr,
  output logic [DW-1:0] rdata
);

  localparam logic [AW-1:0] A_CTRL = BASE;
  localparam logic [AW-1:0] A_LOAD = BASE + AW'(4);
  localparam logic [AW-1:0] A_CUR  = BASE + AW'(8);

  reg_sel_e sel;
  logic     flag;
  logic [DW-1:0] rd_mux;
  logic     unused_wbits;

  always_comb begin
    if      (addr == A_CTRL) sel = SEL_CTRL;
    else if (addr == A_LOAD) sel = SEL_LOAD;
    else if (addr == A_CUR)  sel = SEL_CUR;
    else                     sel = SEL_NONE;
  end

  assign clr = wr_en && (sel == SEL_CUR);
  assign unused_wbits = ^{wdata[DW-1:CW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CTRL) ctrl <= ctrl_t'({wdata[CTL_SRC], wdata[CTL_IE], wdata[CTL_EN]});
      if (sel == SEL_LOAD) reload <= wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                      flag <= 1'b0;
    else if (wrap)                                flag <= 1'b1;
    else if (clr || (rd_en && sel == SEL_CTRL))   flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: begin
        rd_mux[CTL_EN]   = ctrl.en;
        rd_mux[CTL_IE]   = ctrl.ie;
        rd_mux[CTL_SRC]  = ctrl.src;
        rd_mux[CTL_FLAG] = flag;
      end
      SEL_LOAD: rd_mux[CW-1:0] = reload;
      SEL_CUR:  rd_mux[CW-1:0] = count;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end

  // R6: a wrap always leaves the flag set
  a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag);

  // R2: the read bus is quiet when no read was issued
  a_r2_rdata_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

  // R3: masked fields never show upper bits
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel != SEL_CTRL) |=> (rdata[DW-1:CW] == '0));

endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
#(
  parameter int            AW          = 32,
  parameter int            DW          = 32,
  parameter int            CW          = 24,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] BASE        = 32'hE000E010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ref_tick,
  output logic          irq
);

  ctrl_t         ctrl;
  logic [CW-1:0] reload;
  logic [CW-1:0] count;
  logic          clr;
  logic          wrap;
  logic          ref_s;
  logic          tick;

  systick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ref_tick),
    .q   (ref_s)
  );

  systick_regs #(.AW(AW), .DW(DW), .CW(CW), .BASE(BASE)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr),
    .rd_en  (bus_rd),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .count  (count),
    .wrap   (wrap),
    .ctrl   (ctrl),
    .reload (reload),
    .clr    (clr),
    .rdata  (bus_rdata)
  );

  assign tick = ctrl.en && (ctrl.src || ref_s);

  systick_count #(.CW(CW)) u_count (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .clr    (clr),
    .reload (reload),
    .count  (count),
    .wrap   (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= wrap && ctrl.ie;
  end

  // R7: the request lasts one cycle
  a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R7: no request without interrupt enable at the wrap
  a_r7_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
    (wrap && !ctrl.ie) |=> !irq);

  // R9: external source with a low synchronised strobe freezes the count
  a_r9_ext_gate: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.src && !ref_s && !clr) |=> $stable(count));

endmodule

// File: tb/test_systick_timer.sv
module test_systick_timer;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] A_CTRL = 32'hE000E010;
  localparam logic [31:0] A_LOAD = 32'hE000E014;
  localparam logic [31:0] A_CUR  = 32'hE000E018;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ref_tick = 1'b0;
  logic        irq;

  int checks = 0, fails = 0;

  systick_timer i_systick_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements
  logic        m_en, m_ie, m_src, m_flag, m_irq, m_s1, m_s2, m_rdp;
  logic [23:0] m_reload, m_count;

  always @(posedge clk) begin : model
    logic tk, wcur, wrp;
    if (rst) begin
      m_en <= 0; m_ie <= 0; m_src <= 0; m_flag <= 0; m_irq <= 0;
      m_s1 <= 0; m_s2 <= 0; m_rdp <= 0; m_reload <= '0; m_count <= '0;
    end else begin
      tk   = m_en && (m_src || m_s2);
      wcur = bus_wr && bus_addr == A_CUR;
      wrp  = tk && !wcur && m_count == 24'd1;
      m_s1 <= ref_tick; m_s2 <= m_s1; m_rdp <= bus_rd;
      if (wcur)    m_count <= '0;
      else if (tk) m_count <= (m_count == 0) ? m_reload : m_count - 24'd1;
      m_irq <= wrp && m_ie;
      if (wrp) m_flag <= 1'b1;
      else if (wcur || (bus_rd && bus_addr == A_CTRL)) m_flag <= 1'b0;
      if (bus_wr && bus_addr == A_CTRL) {m_src, m_ie, m_en} <= bus_wdata[2:0];
      if (bus_wr && bus_addr == A_LOAD) m_reload <= bus_wdata[23:0];
    end
  end

  function automatic logic [31:0] model_read(logic [31:0] a);
    case (a)
      A_CTRL:  return {15'b0, m_flag, 13'b0, m_src, m_ie, m_en};
      A_LOAD:  return {8'b0, m_reload};
      A_CUR:   return {8'b0, m_count};
      default: return 32'b0;
    endcase
  endfunction

  // Scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin : monitor
    if (!rst) begin
      if (m_rdp && exp_q.size() > 0) begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
      check("R7", {31'b0, irq}, {31'b0, m_irq});
    end
  end

  task automatic bus_write(logic [31:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(logic [31:0] a, string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    exp_q.push_back(model_read(a)); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    int gap;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1", {31'b0, irq}, 32'd0);
    bus_read(A_CTRL, "R1");
    bus_read(A_LOAD, "R1");
    bus_read(A_CUR, "R1");
    // R3: upper bits masked
    bus_write(A_LOAD, 32'hFF000004);
    bus_read(A_LOAD, "R3");
    check("R3", m_reload == 24'h000004 ? 32'd1 : 32'd0, 32'd1);
    // R2: unmapped address
    bus_write(32'hE000E01C, 32'h12345678);
    bus_read(32'hE000E01C, "R2");
    bus_read(A_LOAD, "R2");
    // R5, R4, R7: core clock run with interrupt
    bus_write(A_CUR, 32'h00ABCDEF);
    bus_read(A_CUR, "R5");
    bus_write(A_CTRL, 32'h7);
    for (int i = 0; i < 12; i++) bus_read(A_CUR, "R4");
    // R4: period of reload+1 between requests
    @(negedge clk);
    while (!irq) @(negedge clk);
    gap = 0;
    @(negedge clk);
    while (!irq) begin gap++; @(negedge clk); end
    check("R4", gap + 1, 32'd5);
    // R6: flag set, cleared by read
    bus_read(A_CTRL, "R6");
    bus_read(A_CTRL, "R6");
    repeat (6) @(negedge clk);
    bus_read(A_CTRL, "R6");
    // R5: value write clears flag
    repeat (3) @(negedge clk);
    bus_write(A_CUR, 32'h0);
    bus_read(A_CTRL, "R5");
    // R7: interrupt disabled still flags
    bus_write(A_CTRL, 32'h5);
    repeat (12) @(negedge clk);
    bus_read(A_CTRL, "R7");
    // R10: disabled holds
    bus_write(A_CTRL, 32'h4);
    bus_read(A_CUR, "R10");
    repeat (5) @(negedge clk);
    bus_read(A_CUR, "R10");
    // R8: zero reload
    bus_write(A_LOAD, 32'h0);
    bus_write(A_CUR, 32'h1);
    bus_write(A_CTRL, 32'h7);
    repeat (20) @(negedge clk);
    bus_read(A_CUR, "R8");
    bus_read(A_CTRL, "R8");
    // R9: external strobe
    bus_write(A_LOAD, 32'h3);
    bus_write(A_CTRL, 32'h3);
    for (int i = 0; i < 16; i++) begin
      ref_tick = (i % 3 != 0);
      bus_read(A_CUR, "R9");
    end
    ref_tick = 0;
    repeat (4) @(negedge clk);
    bus_read(A_CUR, "R9");
    bus_read(A_CTRL, "R9");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule